// File: doc/BRIEF.md
# Aliased Sub-Register General Register File

This block holds eight 32-bit general registers and lets each access pick a width. Registers 0 to 3 are data registers. They can be reached as a whole word, as their low half-word, or as either byte of that half-word. Registers 4 and 5 are index registers and registers 6 and 7 are pointer registers. These four accept only whole-word and low-half-word access.

A narrow write merges into the stored word and leaves every bit outside the selected field as it was. There is one write port and two read ports. Each port takes a register number and a 2-bit size code: 00 selects the low byte (bits 7:0), 01 the high byte (bits 15:8), 10 the half-word (bits 15:0) and 11 the full word. Write data is right-aligned, so a field's value is always taken from the low bits of the write data. Reads are combinational and right-aligned too.

Top module: `aliasreg_file`

## Requirements
- R1: Size 11 writes all 32 bits of the addressed register on the clock edge where `wr_en` is high. Size 11 reads return all 32 bits, for every register 0 to 7.
- R2: Size 10 writes `wr_data[15:0]` into bits 15:0 and keeps bits 31:16 unchanged, on any register.
- R3: On registers 0 to 3, size 00 writes `wr_data[7:0]` into bits 7:0 and keeps bits 31:8 unchanged.
- R4: On registers 0 to 3, size 01 writes `wr_data[7:0]` into bits 15:8 and keeps bits 7:0 and bits 31:16 unchanged.
- R5: A write of size 00 or 01 to registers 4 to 7 with `wr_en` high raises `wr_illegal` in that cycle and leaves the register unchanged.
- R6: A read of size 00 or 01 on registers 4 to 7 raises that port's illegal flag and returns zero.
- R7: A legal read returns the selected field zero-extended to 32 bits. A high-byte read returns bits 15:8 in bits 7:0 of the result.
- R8: The two read ports act independently. A read of the register being written in the same cycle returns the value from before the write.
- R9: A high `rst` at a clock edge clears all eight registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register written |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Right-aligned write value |
| wr_illegal | output | 1 | Write request has a byte size on a non-data register |
| ra_idx | input | 3 | Read port A register |
| ra_size | input | 2 | Read port A size code |
| ra_data | output | 32 | Read port A zero-extended field |
| ra_illegal | output | 1 | Read port A illegal size |
| rb_idx | input | 3 | Read port B register |
| rb_size | input | 2 | Read port B size code |
| rb_data | output | 32 | Read port B zero-extended field |
| rb_illegal | output | 1 | Read port B illegal size |

## Verification
The bench first goes after merge faults. A design that writes a whole word on a narrow write, or shifts a high-byte value into the wrong lane, shows up on the next full-word read of that register.

It also drives byte sizes at registers 4 to 7. A design with a missing guard would corrupt an index or pointer register, or return nonzero data with no illegal flag raised.

It reads a register in the same cycle that register is written, which exposes a design that bypasses the new value. Long random runs on both read ports, with mixed sizes, catch a port whose select lines are crossed.

// File: rtl/arf_pkg.sv
package arf_pkg;
   typedef enum logic [1:0] {
      SZ_BLO = 2'b00,
      SZ_BHI = 2'b01,
      SZ_W16 = 2'b10,
      SZ_W32 = 2'b11
   } arf_size_e;

   localparam int unsigned ARF_BYTE_W = 8;
   localparam int unsigned ARF_HALF_W = 16;
endpackage

// File: rtl/arf_access_dec.sv
module arf_access_dec
   import arf_pkg::*;
#(
   parameter int unsigned NUM_REGS  = 8,
   parameter int unsigned BYTE_REGS = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [1:0]       size,
   output logic             legal
);
   logic is_byte;
   logic byteable;

   assign is_byte  = (size == SZ_BLO) || (size == SZ_BHI);
   assign byteable = (32'(idx) < BYTE_REGS);
   assign legal    = !is_byte || byteable;
endmodule

// File: rtl/arf_write_merge.sv
module arf_write_merge
   import arf_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        size,
   output logic [DATA_W-1:0] new_word
);
   always_comb begin
      new_word = old_word;
      case (size)
         SZ_BLO:  new_word[ARF_BYTE_W-1:0] = in_data[ARF_BYTE_W-1:0];
         SZ_BHI:  new_word[ARF_HALF_W-1:ARF_BYTE_W] = in_data[ARF_BYTE_W-1:0];
         SZ_W16:  new_word[ARF_HALF_W-1:0] = in_data[ARF_HALF_W-1:0];
         default: new_word = in_data;
      endcase
   end
endmodule

// File: rtl/arf_read_align.sv
module arf_read_align
   import arf_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] word,
   input  logic [1:0]        size,
   input  logic              legal,
   output logic [DATA_W-1:0] out_data
);
   always_comb begin
      out_data = '0;
      if (legal) begin
         case (size)
            SZ_BLO:  out_data[ARF_BYTE_W-1:0] = word[ARF_BYTE_W-1:0];
            SZ_BHI:  out_data[ARF_BYTE_W-1:0] = word[ARF_HALF_W-1:ARF_BYTE_W];
            SZ_W16:  out_data[ARF_HALF_W-1:0] = word[ARF_HALF_W-1:0];
            default: out_data = word;
         endcase
      end
   end
endmodule

// File: rtl/aliasreg_file.sv
module aliasreg_file
   import arf_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_REGS  = 8,
   parameter int unsigned BYTE_REGS = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_size,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_illegal,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [1:0]        ra_size,
   output logic [DATA_W-1:0] ra_data,
   output logic              ra_illegal,
   input  logic [IDX_W-1:0]  rb_idx,
   input  logic [1:0]        rb_size,
   output logic [DATA_W-1:0] rb_data,
   output logic              rb_illegal
);
   if (DATA_W < ARF_HALF_W) begin : g_bad_width
      $error("DATA_W must hold a half-word");
   end
   if (BYTE_REGS > NUM_REGS) begin : g_bad_byte
      $error("BYTE_REGS exceeds NUM_REGS");
   end
   if ((1 << IDX_W) != NUM_REGS) begin : g_bad_count
      $error("NUM_REGS must be a power of two");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] store_q;
   logic [DATA_W-1:0] merged;
   logic              wr_legal, ra_legal, rb_legal;

   arf_access_dec #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_wdec (
      .idx(wr_idx), .size(wr_size), .legal(wr_legal));
   arf_access_dec #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_adec (
      .idx(ra_idx), .size(ra_size), .legal(ra_legal));
   arf_access_dec #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_bdec (
      .idx(rb_idx), .size(rb_size), .legal(rb_legal));

   arf_write_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word(store_q[wr_idx]), .in_data(wr_data),
      .size(wr_size), .new_word(merged));

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            store_q[r] <= '0;
         else if (wr_en && wr_legal && (wr_idx == IDX_W'(r)))
            store_q[r] <= merged;
      end
   end

   arf_read_align #(.DATA_W(DATA_W)) u_ara (
      .word(store_q[ra_idx]), .size(ra_size), .legal(ra_legal), .out_data(ra_data));
   arf_read_align #(.DATA_W(DATA_W)) u_arb (
      .word(store_q[rb_idx]), .size(rb_size), .legal(rb_legal), .out_data(rb_data));

   assign wr_illegal = wr_en && !wr_legal;
   assign ra_illegal = !ra_legal;
   assign rb_illegal = !rb_legal;
endmodule

// File: rtl/arf_checker.sv
module arf_checker
   import arf_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_REGS  = 8,
   parameter int unsigned BYTE_REGS = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input logic                            clk,
   input logic                            rst,
   input logic                            wr_en,
   input logic [IDX_W-1:0]                wr_idx,
   input logic [1:0]                      wr_size,
   input logic                            wr_illegal,
   input logic [NUM_REGS-1:0][DATA_W-1:0] store_q,
   input logic [IDX_W-1:0]                ra_idx,
   input logic [1:0]                      ra_size,
   input logic [DATA_W-1:0]               ra_data,
   input logic                            ra_illegal
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (store_q == '0)); // R9

   AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      wr_illegal |=> $stable(store_q)); // R5

   AST_BYTE_HIGH_REG_FLAG: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_size[1] && (32'(wr_idx) >= BYTE_REGS)) |-> wr_illegal); // R5

   AST_HALF_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_size == SZ_W16) |=>
      store_q[$past(wr_idx)][DATA_W-1:16] == $past(store_q[wr_idx][DATA_W-1:16])); // R2

   AST_BLO_KEEPS_REST: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_size == SZ_BLO && !wr_illegal) |=>
      store_q[$past(wr_idx)][DATA_W-1:8] == $past(store_q[wr_idx][DATA_W-1:8])); // R3

   AST_BHI_KEEPS_REST: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_size == SZ_BHI && !wr_illegal) |=>
      (store_q[$past(wr_idx)][7:0] == $past(store_q[wr_idx][7:0])) &&
      (store_q[$past(wr_idx)][DATA_W-1:16] == $past(store_q[wr_idx][DATA_W-1:16]))); // R4

   AST_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
      (ra_size != SZ_W32) |-> (ra_data[DATA_W-1:16] == '0)); // R7

   AST_ILLEGAL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      ra_illegal |-> (ra_data == '0)); // R6
endmodule

bind aliasreg_file arf_checker #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)
) chk_i (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
   .wr_illegal(wr_illegal), .store_q(store_q), .ra_idx(ra_idx),
   .ra_size(ra_size), .ra_data(ra_data), .ra_illegal(ra_illegal)
);

// File: tb/aliasreg_file_tb_top.sv
module aliasreg_file_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [2:0]  wr_idx, ra_idx, rb_idx;
   logic [1:0]  wr_size, ra_size, rb_size;
   logic [31:0] wr_data, ra_data, rb_data;
   logic        wr_illegal, ra_illegal, rb_illegal;

   int unsigned model [8];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   aliasreg_file dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
      .wr_data(wr_data), .wr_illegal(wr_illegal),
      .ra_idx(ra_idx), .ra_size(ra_size), .ra_data(ra_data), .ra_illegal(ra_illegal),
      .rb_idx(rb_idx), .rb_size(rb_size), .rb_data(rb_data), .rb_illegal(rb_illegal));

   function automatic bit bad(input int idx, input int sz);
      return (sz < 2) && (idx >= 4);
   endfunction

   function automatic int unsigned rd(input int idx, input int sz);
      if (bad(idx, sz)) return 0;
      case (sz)
         0: return model[idx] & 32'hFF;
         1: return (model[idx] >> 8) & 32'hFF;
         2: return model[idx] & 32'hFFFF;
         default: return model[idx];
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit r, input bit we, input int wi, input int ws,
                       input int unsigned wd, input int ai, input int as,
                       input int bi, input int bs, input string tag);
      @(negedge clk);
      rst = r; wr_en = we; wr_idx = 3'(wi); wr_size = 2'(ws); wr_data = wd;
      ra_idx = 3'(ai); ra_size = 2'(as); rb_idx = 3'(bi); rb_size = 2'(bs);
      #1;
      if (!r) begin
         chk(tag, "ra_data", ra_data, rd(ai, as));
         chk(tag, "ra_illegal", ra_illegal, bad(ai, as));
         chk(tag, "rb_data", rb_data, rd(bi, bs));
         chk(tag, "rb_illegal", rb_illegal, bad(bi, bs));
         chk(tag, "wr_illegal", wr_illegal, we && bad(wi, ws));
      end
      @(posedge clk);
      if (r) begin
         foreach (model[i]) model[i] = 0;
      end else if (we && !bad(wi, ws)) begin
         case (ws)
            0: model[wi] = (model[wi] & 32'hFFFF_FF00) | (wd & 32'hFF);
            1: model[wi] = (model[wi] & 32'hFFFF_00FF) | ((wd & 32'hFF) << 8);
            2: model[wi] = (model[wi] & 32'hFFFF_0000) | (wd & 32'hFFFF);
            default: model[wi] = wd;
         endcase
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      foreach (model[i]) model[i] = 32'hDEAD_BEEF;
      // R9: reset clears everything
      step(1, 0, 0, 0, 0, 0, 3, 0, 3, "R9");
      step(0, 0, 0, 0, 0, 0, 3, 7, 3, "R9 after reset");
      step(0, 0, 0, 0, 0, 3, 3, 5, 3, "R9 after reset");
      // R1: full word writes, data and pointer registers
      step(0, 1, 0, 3, 32'h1234_5678, 0, 3, 1, 3, "R1");
      step(0, 1, 7, 3, 32'hCAFE_F00D, 0, 3, 7, 3, "R1");
      step(0, 0, 0, 0, 0, 7, 3, 0, 3, "R1 readback");
      // R2: half-word write keeps upper half
      step(0, 1, 0, 2, 32'hAAAA_BEEF, 0, 3, 0, 2, "R2");
      step(0, 1, 7, 2, 32'h5555_0101, 0, 3, 0, 2, "R2 readback");
      step(0, 0, 0, 0, 0, 7, 3, 7, 2, "R2 pointer readback");
      // R3 / R4: byte lanes on data register 1
      step(0, 1, 1, 3, 32'hFFFF_FFFF, 1, 3, 1, 3, "R3 setup");
      step(0, 1, 1, 0, 32'h0000_015A, 1, 3, 1, 0, "R3");
      step(0, 1, 1, 1, 32'h1234_563C, 1, 3, 1, 0, "R4");
      step(0, 0, 0, 0, 0, 1, 3, 1, 1, "R4 readback R7");
      step(0, 0, 0, 0, 0, 1, 2, 1, 0, "R7 zero extension");
      // R5: byte write on index/pointer registers is refused
      step(0, 1, 5, 3, 32'h8765_4321, 5, 3, 4, 3, "R5 setup");
      step(0, 1, 5, 0, 32'h0000_00EE, 5, 3, 5, 2, "R5 low byte");
      step(0, 1, 6, 1, 32'h0000_00EE, 5, 3, 6, 3, "R5 high byte");
      step(0, 0, 0, 0, 0, 5, 3, 6, 3, "R5 readback");
      // R6: byte reads on registers 4 to 7
      step(0, 0, 0, 0, 0, 6, 0, 5, 1, "R6");
      step(0, 0, 0, 0, 0, 7, 1, 4, 0, "R6");
      // R8: same-cycle read of the written register
      step(0, 1, 2, 3, 32'h0BAD_CAFE, 2, 3, 2, 2, "R8 old value");
      step(0, 1, 2, 1, 32'h0000_0077, 2, 3, 2, 1, "R8 next");
      step(0, 0, 0, 0, 0, 2, 3, 3, 3, "R8 readback");
      // R8: random mixed traffic on both read ports
      for (int n = 0; n < 1500; n++) begin
         step(0, 1'($urandom), int'($urandom_range(7)), int'($urandom_range(3)),
              $urandom, int'($urandom_range(7)), int'($urandom_range(3)),
              int'($urandom_range(7)), int'($urandom_range(3)), "R8 random");
      end
      // R9: reset in mid-run
      step(1, 1, 3, 3, 32'hFFFF_FFFF, 0, 3, 0, 3, "R9 mid");
      for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, i, 3, 7 - i, 3, "R9 mid clear");
      finish_run();
   end
endmodule